// File: doc/BRIEF.md
# Bank-Group-Aware Column Command Picker

This block holds a short queue of pending DRAM column requests (reads and writes) and, on every clock, names at most one of them as the next column command to issue. Each queued request carries its bank group, bank within the group, target row, a direction bit and a small age counter. The open-row state of all banks is supplied from outside by whatever logic handles activation and precharge. A request whose bank is closed, or open on another row, is never picked here. Instead it is flagged on a per-slot output so the activation logic can act on it.

Selection is first-ready, first-come-first-serve. Only requests that hit an open row and whose bank group has finished its column-to-column spacing may be chosen, and among those the oldest wins. A column command to the same bank group as a previous one must wait the long spacing. A command to any other group only has to wait the short spacing. Because of this, a ready request in another group is naturally taken ahead of an older request that is still waiting in the group just used, and the command stream alternates groups whenever the queue allows it.

Top module: `bank_group_sched`

## Requirements
- R1: While reset is held, and immediately after it, no request is stored. grant_valid is 0, need_act is all zero and enq_ready is 1.
- R2: An offered request (enq_valid with enq_ready high) is stored in the lowest-numbered free slot with age 0. With all 8 slots occupied, enq_ready is 0.
- R3: A stored request is a row hit when bank bit bg*4+bank of bank_open is set and the 8-bit row field at that bank index in bank_row equals its row. A request that is not a hit is never granted, and its need_act bit (bit = slot index) is set.
- R4: Among row hits whose bank group is ready, the one with the largest age is granted. Age starts at 0 and rises by one on each cycle the request waits in the queue.
- R5: Age saturates at 7. Among ready hits of equal age, the lowest slot index wins.
- R6: After a grant in cycle t, no request in the same bank group is granted before cycle t+TCCD_L (default 8). A ready hit in that group is granted exactly at t+TCCD_L if nothing else intervenes.
- R7: After a grant in cycle t, every other bank group is held until cycle t+TCCD_S (default 4). Each grant re-arms the spacing of all groups, and never shortens a longer wait still running.
- R8: A ready hit in another bank group is granted ahead of an older hit whose own group is still within its long spacing.
- R9: grant_idx, grant_bg, grant_bank and grant_write describe the granted slot. That slot is vacated at the next clock edge, so its need_act bit clears and it can be refilled.
- R10: At most one request is granted per cycle, and the grant is combinational from stored state and the current bank state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_valid | input | 1 | New request offered this cycle |
| enq_bg | input | 2 | Bank group of the new request |
| enq_bank | input | 2 | Bank within the group |
| enq_row | input | 8 | Target row |
| enq_write | input | 1 | 1 for write, 0 for read |
| enq_ready | output | 1 | At least one queue slot is free |
| bank_open | input | 16 | Per-bank open flag, bit bg*4+bank |
| bank_row | input | 128 | Open row per bank, 8 bits per bank, bank index b at bits [b*8 +: 8] |
| grant_valid | output | 1 | A column command is issued this cycle |
| grant_idx | output | 3 | Slot of the granted request |
| grant_bg | output | 2 | Bank group of the granted request |
| grant_bank | output | 2 | Bank of the granted request |
| grant_write | output | 1 | Direction of the granted request |
| need_act | output | 8 | Per slot: request waits for a row activation |

## Verification
The hardest situation to reach is a tie between two saturated ages where the younger request sits in the lower slot. The stimulus keeps every bank closed so nothing can be granted, fills slot 1 first, then frees slot 0 with a single grant and refills it. It holds both requests as misses past the saturation point and opens both banks in the same cycle. The same sequence opened early gives the contrasting case, where the older request in the higher slot wins. Bank-group spacing is driven with requests queued ahead of time, so that the exact cycle in which each group becomes free is seen at grant_valid.

// File: rtl/bgs_pkg.sv
// Shared definitions for the bank-group-aware column picker.
// Assumes: bank index is bank_group * banks_per_group + bank.
package bgs_pkg;

    // Direction of a queued column request.
    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } req_dir_e;

    // Flat bank index of a (group, bank) pair.
    function automatic int bank_slot(input int grp, input int bnk, input int per_grp);
        return grp * per_grp + bnk;
    endfunction

    // Spacing re-arm: keep whichever wait is longer.
    function automatic int keep_longer(input int running, input int fresh);
        return (running > fresh) ? running : fresh;
    endfunction

endpackage

// File: rtl/bgs_queue.sv
// Request slots for the column picker.
// Holds up to DEPTH requests; a new one takes the lowest free slot with age 0,
// ages of waiting slots climb and saturate, and a granted slot is vacated at
// the next edge. Assumes the grant index always names an occupied slot.
module bgs_queue #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned BG_W  = 2,
    parameter int unsigned BK_W  = 2,
    parameter int unsigned ROW_W = 8,
    parameter int unsigned AGE_W = 3,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            enq_valid,
    input  logic [BG_W-1:0]                 enq_bg,
    input  logic [BK_W-1:0]                 enq_bank,
    input  logic [ROW_W-1:0]                enq_row,
    input  logic                            enq_write,
    output logic                            enq_ready,
    input  logic                            grant_v,
    input  logic [IDX_W-1:0]                grant_idx,
    output logic [DEPTH-1:0]                vld,
    output logic [DEPTH-1:0][BG_W-1:0]      slot_bg,
    output logic [DEPTH-1:0][BK_W-1:0]      slot_bank,
    output logic [DEPTH-1:0][ROW_W-1:0]     slot_row,
    output logic [DEPTH-1:0]                slot_wr,
    output logic [DEPTH-1:0][AGE_W-1:0]     slot_age
);
    import bgs_pkg::*;

    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    logic             enq_fire;
    logic [IDX_W-1:0] alloc_idx;

    // Lowest free slot for the next arrival.
    always_comb begin
        alloc_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) alloc_idx = IDX_W'(i);
        end
    end

    assign enq_ready = ~&vld;
    assign enq_fire  = enq_valid && enq_ready;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        req_dir_e dir_q;

        // Fill, vacate or age one slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[i]       <= 1'b0;
                slot_age[i]  <= '0;
                slot_bg[i]   <= '0;
                slot_bank[i] <= '0;
                slot_row[i]  <= '0;
                dir_q        <= DIR_RD;
            end else if (enq_fire && alloc_idx == IDX_W'(i)) begin
                vld[i]       <= 1'b1;
                slot_age[i]  <= '0;
                slot_bg[i]   <= enq_bg;
                slot_bank[i] <= enq_bank;
                slot_row[i]  <= enq_row;
                dir_q        <= enq_write ? DIR_WR : DIR_RD;
            end else if (grant_v && grant_idx == IDX_W'(i)) begin
                vld[i]       <= 1'b0;
            end else if (vld[i] && slot_age[i] != AGE_MAX) begin
                slot_age[i]  <= slot_age[i] + 1'b1;
            end
        end

        assign slot_wr[i] = (dir_q == DIR_WR);

        // R5
        age_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vld[i] && slot_age[i] == AGE_MAX && !(grant_v && grant_idx == IDX_W'(i))
            |=> slot_age[i] == AGE_MAX);
    end

    // R2
    enq_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enq_fire |=> vld[$past(alloc_idx)] && slot_age[$past(alloc_idx)] == '0);

    // R9
    grant_vacate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_v |=> !vld[$past(grant_idx)]);

endmodule

// File: rtl/bgs_ccd_timer.sv
// Column-to-column spacing per bank group.
// On each grant the granted group is held for TCCD_L cycles and every other
// group for TCCD_S cycles, never cutting short a longer wait already running.
// A group is ready when its remaining wait is zero. Assumes TCCD_L >= TCCD_S >= 1.
module bgs_ccd_timer #(
    parameter int unsigned NUM_BG = 4,
    parameter int unsigned TCCD_S = 4,
    parameter int unsigned TCCD_L = 8,
    localparam int unsigned BG_W  = $clog2(NUM_BG),
    localparam int unsigned CNT_W = $clog2(TCCD_L + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_v,
    input  logic [BG_W-1:0]   grant_bg,
    output logic [NUM_BG-1:0] bg_ready
);
    import bgs_pkg::*;

    for (genvar g = 0; g < NUM_BG; g++) begin : g_grp
        logic [CNT_W-1:0] wait_q;
        logic [CNT_W-1:0] wait_d;

        // Next remaining wait for this group.
        always_comb begin
            int ticked;
            int fresh;
            ticked = (wait_q == '0) ? 0 : int'(wait_q) - 1;
            fresh  = (grant_bg == BG_W'(g)) ? int'(TCCD_L) - 1 : int'(TCCD_S) - 1;
            if (grant_v) wait_d = CNT_W'(keep_longer(ticked, fresh));
            else         wait_d = CNT_W'(ticked);
        end

        // Hold the remaining wait.
        always_ff @(posedge clk) begin
            if (!rst_n) wait_q <= '0;
            else        wait_q <= wait_d;
        end

        assign bg_ready[g] = (wait_q == '0);

        if (TCCD_L > 1) begin : g_long
            // R6
            grp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                grant_v && grant_bg == BG_W'(g) |=> !bg_ready[g]);
        end
    end

endmodule

// File: rtl/bgs_pick.sv
// Oldest-first choice among eligible slots.
// The eligible slot with the largest age wins; equal ages go to the lowest
// slot index. Assumes eligibility already folds in row hit and group spacing.
module bgs_pick #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned AGE_W = 3,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            elig,
    input  logic [DEPTH-1:0][AGE_W-1:0] age,
    output logic                        pick_v,
    output logic [IDX_W-1:0]            pick_idx
);
    logic [AGE_W-1:0] best_age;

    // Scan upward; only a strictly older slot displaces the current best.
    always_comb begin
        pick_v   = 1'b0;
        pick_idx = '0;
        best_age = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (elig[i] && (!pick_v || age[i] > best_age)) begin
                pick_v   = 1'b1;
                pick_idx = IDX_W'(i);
                best_age = age[i];
            end
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_chk
        // R4
        oldest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pick_v && elig[i] |-> age[pick_idx] >= age[i]);
        // R5
        tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pick_v && elig[i] && age[i] == age[pick_idx] |-> pick_idx <= IDX_W'(i));
    end

endmodule

// File: rtl/bank_group_sched.sv
// Bank-group-aware column command picker (top).
// Marks each stored request as row hit or miss against the supplied bank state,
// masks hits by their group's spacing, and grants the oldest eligible one.
// Misses are reported on need_act and never granted. Assumes bank_open and
// bank_row are stable enough to be sampled combinationally in the grant cycle.
module bank_group_sched #(
    parameter int unsigned DEPTH        = 8,
    parameter int unsigned NUM_BG       = 4,
    parameter int unsigned BANKS_PER_BG = 4,
    parameter int unsigned ROW_W        = 8,
    parameter int unsigned AGE_W        = 3,
    parameter int unsigned TCCD_S       = 4,
    parameter int unsigned TCCD_L       = 8,
    localparam int unsigned BG_W      = $clog2(NUM_BG),
    localparam int unsigned BK_W      = $clog2(BANKS_PER_BG),
    localparam int unsigned NUM_BANKS = NUM_BG * BANKS_PER_BG,
    localparam int unsigned IDX_W     = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enq_valid,
    input  logic [BG_W-1:0]           enq_bg,
    input  logic [BK_W-1:0]           enq_bank,
    input  logic [ROW_W-1:0]          enq_row,
    input  logic                      enq_write,
    output logic                      enq_ready,
    input  logic [NUM_BANKS-1:0]      bank_open,
    input  logic [NUM_BANKS*ROW_W-1:0] bank_row,
    output logic                      grant_valid,
    output logic [IDX_W-1:0]          grant_idx,
    output logic [BG_W-1:0]           grant_bg,
    output logic [BK_W-1:0]           grant_bank,
    output logic                      grant_write,
    output logic [DEPTH-1:0]          need_act
);
    import bgs_pkg::*;

    logic [DEPTH-1:0]              vld;
    logic [DEPTH-1:0][BG_W-1:0]    slot_bg;
    logic [DEPTH-1:0][BK_W-1:0]    slot_bank;
    logic [DEPTH-1:0][ROW_W-1:0]   slot_row;
    logic [DEPTH-1:0]              slot_wr;
    logic [DEPTH-1:0][AGE_W-1:0]   slot_age;
    logic [NUM_BG-1:0]             bg_ready;
    logic [DEPTH-1:0]              row_hit;
    logic [DEPTH-1:0]              elig;

    bgs_queue #(
        .DEPTH (DEPTH),
        .BG_W  (BG_W),
        .BK_W  (BK_W),
        .ROW_W (ROW_W),
        .AGE_W (AGE_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (enq_valid),
        .enq_bg    (enq_bg),
        .enq_bank  (enq_bank),
        .enq_row   (enq_row),
        .enq_write (enq_write),
        .enq_ready (enq_ready),
        .grant_v   (grant_valid),
        .grant_idx (grant_idx),
        .vld       (vld),
        .slot_bg   (slot_bg),
        .slot_bank (slot_bank),
        .slot_row  (slot_row),
        .slot_wr   (slot_wr),
        .slot_age  (slot_age)
    );

    bgs_ccd_timer #(
        .NUM_BG (NUM_BG),
        .TCCD_S (TCCD_S),
        .TCCD_L (TCCD_L)
    ) u_ccd (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant_v  (grant_valid),
        .grant_bg (grant_bg),
        .bg_ready (bg_ready)
    );

    // Row-hit test and spacing mask for every slot.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int b;
            b = bank_slot(int'(slot_bg[i]), int'(slot_bank[i]), int'(BANKS_PER_BG));
            row_hit[i]  = vld[i] && bank_open[b] && (bank_row[b*ROW_W +: ROW_W] == slot_row[i]);
            need_act[i] = vld[i] && !row_hit[i];
            elig[i]     = row_hit[i] && bg_ready[slot_bg[i]];
        end
    end

    bgs_pick #(
        .DEPTH (DEPTH),
        .AGE_W (AGE_W)
    ) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig     (elig),
        .age      (slot_age),
        .pick_v   (grant_valid),
        .pick_idx (grant_idx)
    );

    assign grant_bg    = slot_bg[grant_idx];
    assign grant_bank  = slot_bank[grant_idx];
    assign grant_write = slot_wr[grant_idx];

    // R3
    grant_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !need_act[grant_idx] && vld[grant_idx]);

    if (TCCD_L > 1) begin : g_long_port
        // R6
        same_grp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid |=> !(grant_valid && grant_bg == $past(grant_bg)));
    end

    if (TCCD_S > 1) begin : g_short_port
        // R7
        back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant_valid |=> !grant_valid);
    end

endmodule

// File: tb/bank_group_sched_bench.sv
`timescale 1ns/1ps
module bank_group_sched_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enq_valid = 1'b0;
    logic [1:0]   enq_bg = '0;
    logic [1:0]   enq_bank = '0;
    logic [7:0]   enq_row = '0;
    logic         enq_write = 1'b0;
    logic         enq_ready;
    logic [15:0]  bank_open = '0;
    logic [127:0] bank_row = '0;
    logic         grant_valid;
    logic [2:0]   grant_idx;
    logic [1:0]   grant_bg;
    logic [1:0]   grant_bank;
    logic         grant_write;
    logic [7:0]   need_act;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bank_group_sched u_bank_group_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .enq_valid   (enq_valid),
        .enq_bg      (enq_bg),
        .enq_bank    (enq_bank),
        .enq_row     (enq_row),
        .enq_write   (enq_write),
        .enq_ready   (enq_ready),
        .bank_open   (bank_open),
        .bank_row    (bank_row),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .grant_bg    (grant_bg),
        .grant_bank  (grant_bank),
        .grant_write (grant_write),
        .need_act    (need_act)
    );

    // Vector: enq_v, bg[2], bank[2], row[8], wr, exp_gv, exp_idx[3], exp_wr, exp_need[8]
    localparam int NVEC = 12;
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 2'd0, 8'h10, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00},
        {1'b1, 2'd0, 2'd1, 8'h11, 1'b0, 1'b1, 3'd0, 1'b0, 8'h00},
        {1'b1, 2'd1, 2'd0, 8'h20, 1'b1, 1'b0, 3'd0, 1'b0, 8'h00},
        {1'b1, 2'd2, 2'd0, 8'h99, 1'b0, 1'b0, 3'd0, 1'b0, 8'h00},
        {1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h04},
        {1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b1, 3'd0, 1'b1, 8'h04},
        {1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h04},
        {1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h04},
        {1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h04},
        {1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b1, 3'd1, 1'b0, 8'h04},
        {1'b1, 2'd3, 2'd0, 8'h40, 1'b0, 1'b0, 3'd0, 1'b0, 8'h04},
        {1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0, 3'd0, 1'b0, 8'h05}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
        end
    endtask

    task automatic drv(input logic v, input logic [1:0] bg, input logic [1:0] bk,
                       input logic [7:0] row, input logic wr);
        enq_valid = v;
        enq_bg    = bg;
        enq_bank  = bk;
        enq_row   = row;
        enq_write = wr;
    endtask

    task automatic open_bank(input int b, input logic [7:0] row);
        bank_open[b]       = 1'b1;
        bank_row[b*8 +: 8] = row;
    endtask

    task automatic std_banks();
        bank_open = '0;
        bank_row  = '0;
        open_bank(0, 8'h10);
        open_bank(1, 8'h11);
        open_bank(4, 8'h20);
        open_bank(8, 8'h30);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drv(1'b0, 2'd0, 2'd0, 8'h00, 1'b0);
        repeat (2) @(negedge clk);
        #1;
        chk("R1 reset grant_valid", 32'(grant_valid), 32'd0);
        chk("R1 reset need_act", 32'(need_act), 32'd0);
        chk("R1 reset enq_ready", 32'(enq_ready), 32'd1);
        rst_n = 1'b1;
    endtask

    // Older request in slot 1, younger in slot 0; both banks open after `w` idle steps.
    task automatic age_case(input int w, input int exp_idx, input int exp_bg, input string tag);
        do_reset();
        bank_open = '0;
        bank_row  = '0;
        @(negedge clk); drv(1'b1, 2'd0, 2'd2, 8'h61, 1'b1); #1;
        @(negedge clk); drv(1'b1, 2'd1, 2'd2, 8'h62, 1'b0); #1;
        chk("R3 miss flagged", 32'(need_act), 32'h01);
        @(negedge clk); drv(1'b0, 2'd0, 2'd0, 8'h00, 1'b0); open_bank(2, 8'h61); #1;
        chk("R3 hit granted", 32'(grant_valid), 32'd1);
        chk("R9 idx", 32'(grant_idx), 32'd0);
        chk("R9 write", 32'(grant_write), 32'd1);
        chk("R3 other miss", 32'(need_act), 32'h02);
        @(negedge clk); drv(1'b1, 2'd2, 2'd2, 8'h63, 1'b0); #1;
        for (int k = 0; k < w; k++) begin
            @(negedge clk); drv(1'b0, 2'd0, 2'd0, 8'h00, 1'b0); #1;
        end
        chk("R2 refill slot 0 miss", 32'(need_act), 32'h03);
        chk("R3 misses idle", 32'(grant_valid), 32'd0);
        @(negedge clk); open_bank(6, 8'h62); open_bank(10, 8'h63); #1;
        chk({tag, " grant_valid"}, 32'(grant_valid), 32'd1);
        chk({tag, " grant_idx"}, 32'(grant_idx), 32'(exp_idx));
        chk({tag, " grant_bg"}, 32'(grant_bg), 32'(exp_bg));
        chk({tag, " grant_bank"}, 32'(grant_bank), 32'd2);
        chk("R3 both hit", 32'(need_act), 32'h00);
    endtask

    initial begin
        // Watchdog: a hang counts as a miscompare and still prints the summary.
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Table walk: spacing, group preference, need_act (R3, R6, R7, R8)
        do_reset();
        std_banks();
        for (int s = 0; s < NVEC; s++) begin
            logic [26:0] v;
            v = VEC[s];
            @(negedge clk);
            drv(v[26], v[25:24], v[23:22], v[21:14], v[13]);
            #1;
            chk($sformatf("R7/R8 step %0d grant_valid", s), 32'(grant_valid), 32'(v[12]));
            chk($sformatf("R3 step %0d need_act", s), 32'(need_act), 32'(v[7:0]));
            if (v[12]) begin
                chk($sformatf("R4 step %0d grant_idx", s), 32'(grant_idx), 32'(v[11:9]));
                chk($sformatf("R9 step %0d grant_write", s), 32'(grant_write), 32'(v[8]));
            end
        end

        // R4: older request in a higher slot beats younger in slot 0
        age_case(2, 1, 1, "R4 older wins");
        // R5: both saturated at 7, lowest slot wins
        age_case(9, 0, 2, "R5 saturated tie");

        // Exact spacing boundaries (R6, R7, R8)
        do_reset();
        std_banks();
        for (int s = 0; s <= 17; s++) begin
            @(negedge clk);
            case (s)
                0:  drv(1'b1, 2'd0, 2'd0, 8'h10, 1'b0);
                1:  drv(1'b1, 2'd0, 2'd1, 8'h11, 1'b0);
                2:  drv(1'b1, 2'd1, 2'd0, 8'h20, 1'b0);
                9:  drv(1'b1, 2'd0, 2'd0, 8'h10, 1'b0);
                10: drv(1'b1, 2'd2, 2'd0, 8'h30, 1'b0);
                default: drv(1'b0, 2'd0, 2'd0, 8'h00, 1'b0);
            endcase
            #1;
            case (s)
                1: begin
                    chk("R6 first grant", 32'(grant_valid), 32'd1);
                    chk("R6 first idx", 32'(grant_idx), 32'd0);
                end
                4: chk("R7 other group before short gap", 32'(grant_valid), 32'd0);
                5: begin
                    chk("R8 other group at short gap", 32'(grant_valid), 32'd1);
                    chk("R8 other group idx", 32'(grant_idx), 32'd0);
                    chk("R8 other group bg", 32'(grant_bg), 32'd1);
                end
                8: chk("R6 same group held", 32'(grant_valid), 32'd0);
                9: begin
                    chk("R6 same group released", 32'(grant_valid), 32'd1);
                    chk("R6 same group idx", 32'(grant_idx), 32'd1);
                    chk("R9 bank", 32'(grant_bank), 32'd1);
                end
                12: chk("R7 idle group re-armed", 32'(grant_valid), 32'd0);
                13: begin
                    chk("R7 idle group at short gap", 32'(grant_valid), 32'd1);
                    chk("R7 idle group idx", 32'(grant_idx), 32'd1);
                end
                16: chk("R6 long gap kept", 32'(grant_valid), 32'd0);
                17: begin
                    chk("R6 long gap end", 32'(grant_valid), 32'd1);
                    chk("R6 long gap idx", 32'(grant_idx), 32'd0);
                end
                default: ;
            endcase
        end

        // Full queue, removal and slot reuse (R2, R9)
        do_reset();
        bank_open = '0;
        bank_row  = '0;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            drv(1'b1, 2'(j % 4), 2'(j / 4), 8'(8'h80 + j), 1'b0);
            #1;
        end
        @(negedge clk); drv(1'b1, 2'd0, 2'd3, 8'h5A, 1'b0); #1;
        chk("R2 full enq_ready", 32'(enq_ready), 32'd0);
        chk("R2 full need_act", 32'(need_act), 32'hFF);
        @(negedge clk); drv(1'b0, 2'd0, 2'd0, 8'h00, 1'b0); open_bank(12, 8'h83); #1;
        chk("R9 grant idx", 32'(grant_idx), 32'd3);
        chk("R9 grant bg", 32'(grant_bg), 32'd3);
        chk("R9 grant bank", 32'(grant_bank), 32'd0);
        @(negedge clk); drv(1'b1, 2'd0, 2'd3, 8'h5A, 1'b0); #1;
        chk("R9 slot vacated", 32'(need_act), 32'hF7);
        chk("R9 enq_ready back", 32'(enq_ready), 32'd1);
        @(negedge clk); drv(1'b0, 2'd0, 2'd0, 8'h00, 1'b0); #1;
        chk("R2 lowest free slot reused", 32'(need_act), 32'hFF);
        chk("R2 full again", 32'(enq_ready), 32'd0);
        chk("R10 no grant on misses", 32'(grant_valid), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule